// File: doc/BRIEF.md
# Two-Thread Issue Slot Allocator

The allocator picks, in every clock, up to four ready instructions from two per-thread ready lists and places them into four issue slots. Each ready entry carries a tag that names one of seven functional-unit pipelines. Each granted slot reports the thread it came from, the entry index inside that thread's list, and the pipeline it is steered to. Dependency tracking, fetch and decode happen upstream. The allocator is a combinational selection network around a single-bit turn register.

A policy input picks one of two issue policies. In fine-grained mode, every slot granted in a cycle comes from a single thread, and the preferred thread alternates every cycle. In simultaneous mode, the preferred thread takes its pick first. The other thread then fills the slots that remain, using only pipelines that are still free. In both modes a preferred thread that is stalled, or has nothing eligible, is passed over, and the other thread takes its place.

Top module: `ts_issue_alloc`

## Requirements
- R1: While reset is asserted all slot outputs are zero. Out of reset at most SLOTS slots are valid, and the valid slots always form an unbroken run that starts at slot 0.
- R2: A unit tag of 0 to UNITS-1 selects a pipeline, and a tag of UNITS or more (7 by default) means "no pipeline". An entry that carries such a tag is never granted. A granted slot's unit output equals the tag of the entry it names.
- R3: No two valid slots in one cycle carry the same unit. A ready entry whose unit is already claimed is not granted in that cycle.
- R4: When sim_mode is 0 (fine-grained), all valid slots in a cycle carry the same thread ID.
- R5: A turn bit starts at 0 (thread 0) when reset is released and toggles on every clock edge. When the turn thread is eligible, slot 0 carries its ID.
- R6: A thread is eligible when its stall flag is low and it has at least one ready entry with a legal tag. If the turn thread is not eligible, the other thread becomes primary. A stalled thread never appears in any valid slot.
- R7: When sim_mode is 1 (simultaneous), the non-primary thread, if not stalled, fills the slots the primary left empty, using only units that are still free.
- R8: If neither thread is eligible, all slot_valid bits are low.
- R9: Slots fill in this order: the primary thread's grants first, then the secondary thread's. Within a thread, entries are taken from the lowest index upward, so the lower index wins a contested unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sim_mode | input | 1 | 0 = fine-grained, 1 = simultaneous |
| t0_rdy | input | ENTRIES | Thread 0 ready bit per entry |
| t0_unit | input | ENTRIES*UW | Thread 0 unit tag per entry, entry e at [e*UW +: UW] |
| t0_stall | input | 1 | Thread 0 stalled |
| t1_rdy | input | ENTRIES | Thread 1 ready bit per entry |
| t1_unit | input | ENTRIES*UW | Thread 1 unit tag per entry |
| t1_stall | input | 1 | Thread 1 stalled |
| slot_valid | output | SLOTS | Slot s carries a grant |
| slot_tid | output | SLOTS | Thread ID of slot s |
| slot_idx | output | SLOTS*IW | Entry index of slot s at [s*IW +: IW] |
| slot_unit | output | SLOTS*UW | Unit select of slot s at [s*UW +: UW] |

## Verification
The bench builds the block with its defaults: eight entries per thread, four slots and seven units, so UW = 3 and the tag 7 is the illegal code. Eight entries against seven units means one thread alone can ask for every pipeline, and can also ask for one pipeline twice. With four slots against seven units, the slot limit and unit contention both cut off grants, often in the same cycle. The directed vectors hit contested units, stalled and empty threads, illegal tags and back-to-back turn changes. Random vectors then mix both policies.

// File: rtl/ts_pkg.sv
package ts_pkg;
   typedef enum logic {
      POL_FINE = 1'b0,
      POL_SMT  = 1'b1
   } policy_e;

   typedef enum logic {
      THR_0 = 1'b0,
      THR_1 = 1'b1
   } thread_e;
endpackage

// File: rtl/ts_turn_sel.sv
module ts_turn_sel
   import ts_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  policy_e policy,
   input  logic    elig0,
   input  logic    elig1,
   input  logic    stall0,
   input  logic    stall1,
   output thread_e prim,
   output logic    prim_en,
   output logic    sec_en
);
   thread_e turn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) turn_q <= THR_0;
      else        turn_q <= (turn_q == THR_0) ? THR_1 : THR_0;
   end

   logic turn_elig;
   logic sec_stall;

   always_comb begin
      turn_elig = (turn_q == THR_1) ? elig1 : elig0;
      if (turn_elig) prim = turn_q;
      else           prim = (turn_q == THR_0) ? THR_1 : THR_0;
      prim_en   = (prim == THR_1) ? elig1 : elig0;
      sec_stall = (prim == THR_1) ? stall0 : stall1;
      sec_en    = (policy == POL_SMT) && !sec_stall;
   end
endmodule

// File: rtl/ts_thread_pick.sv
module ts_thread_pick #(
   parameter int ENTRIES = 8,
   parameter int SLOTS   = 4,
   parameter int UNITS   = 7,
   parameter int UW      = 3,
   parameter int CW      = 3
) (
   input  logic                  en,
   input  logic [ENTRIES-1:0]    rdy,
   input  logic [ENTRIES*UW-1:0] unit,
   input  logic [UNITS-1:0]      claim_in,
   input  logic [CW-1:0]         cnt_in,
   output logic [ENTRIES-1:0]    pick,
   output logic [UNITS-1:0]      claim_out,
   output logic [CW-1:0]         cnt_out
);
   localparam int CODES = 1 << UW;

   logic [CODES-1:0] cl;
   logic [UW-1:0]    u;
   logic [CW-1:0]    cnt;

   always_comb begin
      cl            = '0;
      cl[UNITS-1:0] = claim_in;
      cnt           = cnt_in;
      pick          = '0;
      u             = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         u = unit[i*UW +: UW];
         if (en && rdy[i] && (u < UW'(UNITS)) && !cl[u] && (cnt < CW'(SLOTS))) begin
            pick[i] = 1'b1;
            cl[u]   = 1'b1;
            cnt     = cnt + CW'(1);
         end
      end
      claim_out = cl[UNITS-1:0];
      cnt_out   = cnt;
   end
endmodule

// File: rtl/ts_slot_pack.sv
module ts_slot_pack
   import ts_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int SLOTS   = 4,
   parameter int UW      = 3,
   parameter int IW      = 3,
   parameter int CW      = 3
) (
   input  thread_e               prim,
   input  logic [ENTRIES-1:0]    pick_p,
   input  logic [ENTRIES-1:0]    pick_s,
   input  logic [ENTRIES*UW-1:0] unit_p,
   input  logic [ENTRIES*UW-1:0] unit_s,
   input  logic [CW-1:0]         total,
   output logic [SLOTS-1:0]      valid,
   output logic [SLOTS-1:0]      tid,
   output logic [SLOTS*IW-1:0]   idx,
   output logic [SLOTS*UW-1:0]   unt
);
   localparam int CAND = 2 * ENTRIES;

   logic [CAND-1:0]    cand;
   logic [CAND*UW-1:0] cand_unit;

   assign cand      = {pick_s, pick_p};
   assign cand_unit = {unit_s, unit_p};

   for (genvar s = 0; s < SLOTS; s++) begin : g_valid
      assign valid[s] = (CW'(s) < total);
   end

   int k;

   always_comb begin
      tid = '0;
      idx = '0;
      unt = '0;
      k   = 0;
      for (int j = 0; j < CAND; j++) begin
         if (cand[j] && (k < SLOTS)) begin
            for (int s = 0; s < SLOTS; s++) begin
               if (s == k) begin
                  tid[s]          = (j < ENTRIES) ? prim : ~prim;
                  idx[s*IW +: IW] = IW'(j % ENTRIES);
                  unt[s*UW +: UW] = cand_unit[j*UW +: UW];
               end
            end
            k = k + 1;
         end
      end
   end
endmodule

// File: rtl/ts_issue_alloc.sv
module ts_issue_alloc
   import ts_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int SLOTS   = 4,
   parameter int UNITS   = 7,
   parameter int UW      = $clog2(UNITS + 1),
   parameter int IW      = $clog2(ENTRIES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sim_mode,
   input  logic [ENTRIES-1:0]    t0_rdy,
   input  logic [ENTRIES*UW-1:0] t0_unit,
   input  logic                  t0_stall,
   input  logic [ENTRIES-1:0]    t1_rdy,
   input  logic [ENTRIES*UW-1:0] t1_unit,
   input  logic                  t1_stall,
   output logic [SLOTS-1:0]      slot_valid,
   output logic [SLOTS-1:0]      slot_tid,
   output logic [SLOTS*IW-1:0]   slot_idx,
   output logic [SLOTS*UW-1:0]   slot_unit
);
   localparam int CW = $clog2(SLOTS + 1);

   if (ENTRIES < 2)           begin : g_bad_entries $error("ENTRIES must be at least 2"); end
   if (SLOTS < 1)             begin : g_bad_slots   $error("SLOTS must be at least 1"); end
   if (SLOTS > 2 * ENTRIES)   begin : g_bad_ratio   $error("SLOTS exceeds total entries"); end
   if (UNITS < 2)             begin : g_bad_units   $error("UNITS must be at least 2"); end
   if ((1 << UW) <= UNITS)    begin : g_bad_uw      $error("UW leaves no illegal tag code"); end
   if ((1 << IW) < ENTRIES)   begin : g_bad_iw      $error("IW too narrow for ENTRIES"); end

   policy_e policy;
   assign policy = policy_e'(sim_mode);

   logic [ENTRIES-1:0] vr0, vr1;
   for (genvar e = 0; e < ENTRIES; e++) begin : g_filter
      assign vr0[e] = t0_rdy[e] && (t0_unit[e*UW +: UW] < UW'(UNITS));
      assign vr1[e] = t1_rdy[e] && (t1_unit[e*UW +: UW] < UW'(UNITS));
   end

   logic elig0, elig1;
   assign elig0 = !t0_stall && (|vr0);
   assign elig1 = !t1_stall && (|vr1);

   thread_e prim;
   logic    prim_en, sec_en;

   ts_turn_sel u_turn (
      .clk     (clk),
      .rst_n   (rst_n),
      .policy  (policy),
      .elig0   (elig0),
      .elig1   (elig1),
      .stall0  (t0_stall),
      .stall1  (t1_stall),
      .prim    (prim),
      .prim_en (prim_en),
      .sec_en  (sec_en)
   );

   logic [1:0][ENTRIES-1:0]    rdy_ord;
   logic [1:0][ENTRIES*UW-1:0] unit_ord;
   logic [1:0]                 en_ord;
   logic [1:0][ENTRIES-1:0]    pick_ord;
   logic [2:0][UNITS-1:0]      claim_chain;
   logic [2:0][CW-1:0]         cnt_chain;
   logic [UNITS-1:0]           claim_unused;

   assign rdy_ord[0]     = (prim == THR_1) ? vr1 : vr0;
   assign rdy_ord[1]     = (prim == THR_1) ? vr0 : vr1;
   assign unit_ord[0]    = (prim == THR_1) ? t1_unit : t0_unit;
   assign unit_ord[1]    = (prim == THR_1) ? t0_unit : t1_unit;
   assign en_ord         = {sec_en, prim_en};
   assign claim_chain[0] = '0;
   assign cnt_chain[0]   = '0;
   assign claim_unused   = claim_chain[2];

   for (genvar p = 0; p < 2; p++) begin : g_pick
      ts_thread_pick #(
         .ENTRIES (ENTRIES),
         .SLOTS   (SLOTS),
         .UNITS   (UNITS),
         .UW      (UW),
         .CW      (CW)
      ) u_pick (
         .en        (en_ord[p]),
         .rdy       (rdy_ord[p]),
         .unit      (unit_ord[p]),
         .claim_in  (claim_chain[p]),
         .cnt_in    (cnt_chain[p]),
         .pick      (pick_ord[p]),
         .claim_out (claim_chain[p+1]),
         .cnt_out   (cnt_chain[p+1])
      );
   end

   logic [SLOTS-1:0]    pk_valid, pk_tid;
   logic [SLOTS*IW-1:0] pk_idx;
   logic [SLOTS*UW-1:0] pk_unit;

   ts_slot_pack #(
      .ENTRIES (ENTRIES),
      .SLOTS   (SLOTS),
      .UW      (UW),
      .IW      (IW),
      .CW      (CW)
   ) u_pack (
      .prim   (prim),
      .pick_p (pick_ord[0]),
      .pick_s (pick_ord[1]),
      .unit_p (unit_ord[0]),
      .unit_s (unit_ord[1]),
      .total  (cnt_chain[2]),
      .valid  (pk_valid),
      .tid    (pk_tid),
      .idx    (pk_idx),
      .unt    (pk_unit)
   );

   assign slot_valid = rst_n ? pk_valid : '0;
   assign slot_tid   = rst_n ? pk_tid   : '0;
   assign slot_idx   = rst_n ? pk_idx   : '0;
   assign slot_unit  = rst_n ? pk_unit  : '0;
endmodule

// File: rtl/ts_issue_alloc_chk.sv
module ts_issue_alloc_chk #(
   parameter int ENTRIES = 8,
   parameter int SLOTS   = 4,
   parameter int UNITS   = 7,
   parameter int UW      = 3,
   parameter int IW      = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  sim_mode,
   input logic [ENTRIES-1:0]    t0_rdy,
   input logic [ENTRIES*UW-1:0] t0_unit,
   input logic                  t0_stall,
   input logic [ENTRIES-1:0]    t1_rdy,
   input logic [ENTRIES*UW-1:0] t1_unit,
   input logic                  t1_stall,
   input logic [SLOTS-1:0]      slot_valid,
   input logic [SLOTS-1:0]      slot_tid,
   input logic [SLOTS*IW-1:0]   slot_idx,
   input logic [SLOTS*UW-1:0]   slot_unit
);
   logic el0, el1, both_el;

   always_comb begin
      el0 = 1'b0;
      el1 = 1'b0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (t0_rdy[e] && (t0_unit[e*UW +: UW] < UW'(UNITS))) el0 = 1'b1;
         if (t1_rdy[e] && (t1_unit[e*UW +: UW] < UW'(UNITS))) el1 = 1'b1;
      end
      el0     = el0 && !t0_stall;
      el1     = el1 && !t1_stall;
      both_el = el0 && el1;
   end

   always @(posedge clk) begin
      if (!rst_n) p_quiet_reset_r1: assert (slot_valid == '0);
   end

   for (genvar s = 0; s + 1 < SLOTS; s++) begin : g_run
      p_packed_r1: assert property (@(posedge clk) disable iff (!rst_n)
         slot_valid[s+1] |-> slot_valid[s]);
   end

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      p_unit_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
         slot_valid[s] |-> (slot_unit[s*UW +: UW] < UW'(UNITS)));
      p_stall0_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (t0_stall && slot_valid[s]) |-> slot_tid[s]);
      p_stall1_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (t1_stall && slot_valid[s]) |-> !slot_tid[s]);
      if (s > 0) begin : g_fine
         p_one_thread_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!sim_mode && slot_valid[s]) |-> (slot_tid[s] == slot_tid[0]));
      end
      for (genvar b = s + 1; b < SLOTS; b++) begin : g_pair
         p_unit_distinct_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_valid[s] && slot_valid[b]) |->
            (slot_unit[s*UW +: UW] != slot_unit[b*UW +: UW]));
      end
   end

   p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!el0 && !el1) |-> (slot_valid == '0));

   p_turn_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (both_el && $past(both_el) && $past(rst_n)) |-> (slot_tid[0] != $past(slot_tid[0])));
endmodule

bind ts_issue_alloc ts_issue_alloc_chk #(
   .ENTRIES (ENTRIES),
   .SLOTS   (SLOTS),
   .UNITS   (UNITS),
   .UW      (UW),
   .IW      (IW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sim_mode   (sim_mode),
   .t0_rdy     (t0_rdy),
   .t0_unit    (t0_unit),
   .t0_stall   (t0_stall),
   .t1_rdy     (t1_rdy),
   .t1_unit    (t1_unit),
   .t1_stall   (t1_stall),
   .slot_valid (slot_valid),
   .slot_tid   (slot_tid),
   .slot_idx   (slot_idx),
   .slot_unit  (slot_unit)
);

// File: tb/tb_ts_issue_alloc.sv
`timescale 1ns/1ps
module tb_ts_issue_alloc;
   localparam int E  = 8;
   localparam int S  = 4;
   localparam int U  = 7;
   localparam int UW = 3;
   localparam int IW = 3;
   localparam int OW = 2 * S + S * IW + S * UW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sim_mode = 1'b0;
   logic [E-1:0]  t0_rdy = '0, t1_rdy = '0;
   logic [E*UW-1:0] t0_unit = '0, t1_unit = '0;
   logic          t0_stall = 1'b0, t1_stall = 1'b0;
   logic [S-1:0]  slot_valid, slot_tid;
   logic [S*IW-1:0] slot_idx;
   logic [S*UW-1:0] slot_unit;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   logic tb_turn;

   logic [OW-1:0] exp_q[$];
   string         tag_q[$];

   always #2.5 clk = ~clk;

   ts_issue_alloc dut (
      .clk(clk), .rst_n(rst_n), .sim_mode(sim_mode),
      .t0_rdy(t0_rdy), .t0_unit(t0_unit), .t0_stall(t0_stall),
      .t1_rdy(t1_rdy), .t1_unit(t1_unit), .t1_stall(t1_stall),
      .slot_valid(slot_valid), .slot_tid(slot_tid),
      .slot_idx(slot_idx), .slot_unit(slot_unit)
   );

   // Turn per R5: 0 at reset release, toggles every edge.
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) tb_turn <= 1'b0;
      else        tb_turn <= ~tb_turn;
   end

   function automatic logic [OW-1:0] model(
      input logic m, input logic [E-1:0] r0, input logic [E*UW-1:0] u0, input logic s0,
      input logic [E-1:0] r1, input logic [E*UW-1:0] u1, input logic s1, input logic trn);
      logic el0, el1, prim, th, en, rr;
      logic [7:0] used;
      logic [UW-1:0] uu;
      logic [S-1:0] v, t;
      logic [S*IW-1:0] ix;
      logic [S*UW-1:0] un;
      int k;
      el0 = 0; el1 = 0; used = '0; v = '0; t = '0; ix = '0; un = '0; k = 0;
      for (int e = 0; e < E; e++) begin
         if (r0[e] && u0[e*UW +: UW] < 3'(U)) el0 = 1;
         if (r1[e] && u1[e*UW +: UW] < 3'(U)) el1 = 1;
      end
      el0 = el0 && !s0;
      el1 = el1 && !s1;
      prim = ((trn ? el1 : el0)) ? trn : ~trn;
      for (int p = 0; p < 2; p++) begin
         th = (p == 0) ? prim : ~prim;
         en = (p == 0) ? (prim ? el1 : el0) : (m && !(prim ? s0 : s1));
         for (int e = 0; e < E; e++) begin
            uu = th ? u1[e*UW +: UW] : u0[e*UW +: UW];
            rr = th ? r1[e] : r0[e];
            if (en && rr && uu < 3'(U) && !used[uu] && k < S) begin
               v[k] = 1; t[k] = th;
               ix[k*IW +: IW] = 3'(e);
               un[k*UW +: UW] = uu;
               used[uu] = 1;
               k++;
            end
         end
      end
      return {v, t, ix, un};
   endfunction

   task automatic apply(input string tag, input logic m,
                        input logic [E-1:0] r0, input logic [E*UW-1:0] u0, input logic s0,
                        input logic [E-1:0] r1, input logic [E*UW-1:0] u1, input logic s1);
      @(negedge clk);
      sim_mode = m; t0_rdy = r0; t0_unit = u0; t0_stall = s0;
      t1_rdy = r1; t1_unit = u1; t1_stall = s1;
      exp_q.push_back(model(m, r0, u0, s0, r1, u1, s1, tb_turn));
      tag_q.push_back(tag);
   endtask

   // Monitor: compare one cycle's slots against the queued expectation.
   initial begin
      logic [OW-1:0] got, ex;
      string tg;
      forever begin
         @(negedge clk);
         #1;
         if (exp_q.size() > 0) begin
            ex = exp_q.pop_front();
            tg = tag_q.pop_front();
            got = {slot_valid, slot_tid, slot_idx, slot_unit};
            checks++;
            if (got !== ex) begin
               fails++;
               $display("FAIL %s: got %h expected %h", tg, got, ex);
            end
         end
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run hung, got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   // Unit tag lists, entry 0 in the low bits.
   function automatic logic [E*UW-1:0] tags(input int a0, a1, a2, a3, a4, a5, a6, a7);
      return {3'(a7), 3'(a6), 3'(a5), 3'(a4), 3'(a3), 3'(a2), 3'(a1), 3'(a0)};
   endfunction

   initial begin
      // R1: outputs quiet under reset even with ready work.
      t0_rdy = 8'hFF; t0_unit = tags(0,1,2,3,4,5,6,0);
      repeat (3) @(negedge clk);
      #1;
      checks++;
      if (slot_valid !== '0 || slot_tid !== '0 || slot_idx !== '0 || slot_unit !== '0) begin
         fails++;
         $display("FAIL R1 reset: got %b expected 0000", slot_valid);
      end
      @(negedge clk);
      rst_n = 1'b1;

      // R1/R9: thread 0 fills all slots from the lowest index.
      apply("R1 R9 fill", 0, 8'hFF, tags(0,1,2,3,4,5,6,0), 0, 8'h00, '0, 0);
      // R3: every entry wants unit 2, only one issues.
      apply("R3 conflict", 0, 8'hFF, tags(2,2,2,2,2,2,2,2), 0, 8'h00, '0, 0);
      apply("R3 R9 partial", 1, 8'h0F, tags(5,5,1,1,0,0,0,0), 0, 8'h0F, tags(5,1,3,3,0,0,0,0), 0);
      // R4/R5: both threads ready, fine mode alternates.
      for (int i = 0; i < 4; i++)
         apply("R4 R5 alternate", 0, 8'h0F, tags(0,1,2,3,0,0,0,0), 0, 8'h0F, tags(4,5,6,0,0,0,0,0), 0);
      // R6: stalled thread passed over, both parities of turn.
      apply("R6 stall t0", 0, 8'h03, tags(0,1,0,0,0,0,0,0), 1, 8'h03, tags(2,3,0,0,0,0,0,0), 0);
      apply("R6 stall t0", 0, 8'h03, tags(0,1,0,0,0,0,0,0), 1, 8'h03, tags(2,3,0,0,0,0,0,0), 0);
      apply("R6 empty t1", 1, 8'h01, tags(6,0,0,0,0,0,0,0), 0, 8'h00, tags(1,1,1,1,1,1,1,1), 0);
      apply("R6 stall t1 smt", 1, 8'h01, tags(6,0,0,0,0,0,0,0), 0, 8'hFF, tags(0,1,2,3,4,5,6,0), 1);
      // R2: illegal tag 7 never issues; a thread holding only tag 7 is not eligible.
      apply("R2 tag7", 0, 8'hFF, tags(7,7,7,3,7,7,7,7), 0, 8'h00, '0, 0);
      apply("R2 tag7 only", 0, 8'hFF, tags(7,7,7,7,7,7,7,7), 0, 8'h01, tags(4,0,0,0,0,0,0,0), 0);
      // R7: simultaneous fill with a shared unit.
      apply("R7 fill", 1, 8'h03, tags(0,1,0,0,0,0,0,0), 0, 8'h0F, tags(1,2,3,4,0,0,0,0), 0);
      apply("R7 fill", 1, 8'h03, tags(0,1,0,0,0,0,0,0), 0, 8'h0F, tags(1,2,3,4,0,0,0,0), 0);
      // R8: nothing eligible.
      apply("R8 both stall", 1, 8'hFF, tags(0,1,2,3,4,5,6,0), 1, 8'hFF, tags(0,1,2,3,4,5,6,0), 1);
      apply("R8 both empty", 0, 8'h00, tags(0,1,2,3,4,5,6,0), 0, 8'h00, tags(0,1,2,3,4,5,6,0), 0);

      for (int i = 0; i < 800; i++) begin
         logic [E*UW-1:0] ua, ub;
         ua = '0; ub = '0;
         for (int e = 0; e < E; e++) begin
            ua[e*UW +: UW] = 3'($urandom_range(0, 7));
            ub[e*UW +: UW] = 3'($urandom_range(0, 7));
         end
         apply("R3 R4 R7 R9 random", 1'($urandom_range(0, 1)),
               8'($urandom), ua, ($urandom_range(0, 4) == 0),
               8'($urandom), ub, ($urandom_range(0, 4) == 0));
      end

      repeat (3) @(negedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule